// File: doc/BRIEF.md
# Reference-Counted Buffer Address Manager

This block keeps track of which rows of a shared packet buffer are free. An input controller that needs a place to store an arriving packet takes the address at the head of the free pool through a valid/request handshake. Once the packet has been accepted, the controller commits the address together with its fan-out: the number of output queues that will each send a copy of the packet.

Every time an output finishes sending its copy, it releases the address. The block keeps a count for each address and lowers it by one on each release. The address goes back into the free pool only when the last copy has left. A unicast packet has a fan-out of one. A multicast packet is stored once and released once per destination.

Immediately after reset, every address is free and is handed out in ascending order. An address that has been recycled is handed out again in the order in which it was freed. The number of free addresses is always visible at the ports. A release aimed at an address that no output holds is dropped and raises a sticky error flag.

Top module: `bufaddr_refmgr`

## Requirements
- R1: After reset, `free_count` equals DEPTH, `alloc_vld` is 1, `alloc_addr` is 0 and `release_err` is 0.
- R2: An allocation completes on a rising edge where `alloc_req` and `alloc_vld` are both 1. From the next cycle, `free_count` is one lower and `alloc_addr` presents the next free address.
- R3: `alloc_vld` is 0 exactly when `free_count` is 0. While it is 0, `alloc_req` changes nothing.
- R4: After a commit with a fan-out N of 1 or more, the address stays out of the pool through the first N-1 releases. The cycle after the N-th release, `free_count` rises by one.
- R5: Addresses are first issued in ascending order 0 to DEPTH-1. After that, freed addresses are issued in the order in which they re-entered the pool.
- R6: A commit with a fan-out of 0 returns the address to the pool at once: `free_count` is one higher in the next cycle.
- R7: A release to an address whose count is 0 leaves `free_count` and all counts unchanged, and sets `release_err`. The flag stays at 1 until reset.
- R8: An allocation and a release in the same cycle both take effect, and `free_count` reflects both.
- R9: When a fan-out-0 commit and a final release occur in the same cycle, both addresses enter the pool. The committed one enters first.
- R10: `free_count` always equals the number of addresses that can still be allocated. It never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Input controller takes the offered address |
| alloc_vld | output | 1 | A free address is on offer |
| alloc_addr | output | AW | Address on offer |
| commit_vld | input | 1 | Commit a stored packet's address |
| commit_addr | input | AW | Address being committed |
| commit_fanout | input | CW | Number of outputs holding a copy (0 to NOUT) |
| release_vld | input | 1 | An output has finished with an address |
| release_addr | input | AW | Address being released |
| free_count | output | CNTW | Number of free addresses |
| release_err | output | 1 | Sticky flag: a release targeted an unheld address |

## Verification
The hardest state to reach from the ports is the point where the ascending fresh supply is used up and the pool can only offer recycled addresses. Reaching it requires spending every address, and the recycled addresses must have entered through every kind of return: immediate, last-of-many, simultaneous with an allocation, and paired in the same cycle. The bench uses a 16-entry pool. A vector table recycles five addresses, including one cycle with two returns. Directed steps then drain the fresh supply, check that the recycled five come back in their entry order, confirm that the pool refuses to go below empty, and reset again.

// File: rtl/refmgr_pkg.sv
package refmgr_pkg;

    typedef enum logic [1:0] {
        REL_NONE = 2'd0,
        REL_DEC  = 2'd1,
        REL_LAST = 2'd2,
        REL_BAD  = 2'd3
    } rel_kind_e;

    function automatic int unsigned wrap_inc(int unsigned p, int unsigned lim);
        return (p + 1 >= lim) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/refmgr_freeq.sv
module refmgr_freeq #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH),
    parameter int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pop,
    input  logic            push0,
    input  logic [AW-1:0]   push0_addr,
    input  logic            push1,
    input  logic [AW-1:0]   push1_addr,
    output logic            head_vld,
    output logic [AW-1:0]   head_addr,
    output logic [CNTW-1:0] avail,
    output logic            pop_ok
);
    import refmgr_pkg::*;

    localparam logic [CNTW-1:0] DEPTH_C = CNTW'(DEPTH);

    typedef struct packed {
        logic [CNTW-1:0] fresh;
        logic [AW-1:0]   rd;
        logic [AW-1:0]   wr;
        logic [CNTW-1:0] ring;
    } fq_state_t;

    fq_state_t   s_d, s_q;
    logic [AW-1:0] mem_d [DEPTH];
    logic [AW-1:0] mem_q [DEPTH];
    logic          use_fresh;
    logic [AW-1:0] wp;

    always_comb begin
        use_fresh = s_q.fresh < DEPTH_C;
        head_addr = use_fresh ? s_q.fresh[AW-1:0] : mem_q[s_q.rd];
        avail     = (DEPTH_C - s_q.fresh) + s_q.ring;
        head_vld  = avail != '0;
        pop_ok    = pop && head_vld;
        s_d       = s_q;
        mem_d     = mem_q;
        wp        = s_q.wr;

        if (pop_ok) begin
            if (use_fresh) begin
                s_d.fresh = s_q.fresh + 1'b1;
            end else begin
                s_d.rd = AW'(wrap_inc(32'(s_q.rd), DEPTH));
            end
        end
        if (push0) begin
            mem_d[wp] = push0_addr;
            wp        = AW'(wrap_inc(32'(wp), DEPTH));
        end
        if (push1) begin
            mem_d[wp] = push1_addr;
            wp        = AW'(wrap_inc(32'(wp), DEPTH));
        end
        s_d.wr   = wp;
        s_d.ring = s_q.ring + CNTW'(push0) + CNTW'(push1)
                 - CNTW'(pop_ok && !use_fresh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ring <= DEPTH_C) && (s_q.fresh <= DEPTH_C));

    p_empty_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !head_vld) |=> (s_q.fresh == $past(s_q.fresh)) && (s_q.rd == $past(s_q.rd)));

    p_fresh_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && (s_q.fresh < DEPTH_C)) |=> (s_q.rd == $past(s_q.rd)));

endmodule

// File: rtl/refmgr_refcnt.sv
module refmgr_refcnt #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cm_vld,
    input  logic [AW-1:0] cm_addr,
    input  logic [CW-1:0] cm_fo,
    input  logic          rl_vld,
    input  logic [AW-1:0] rl_addr,
    output logic          cm_free,
    output logic          rl_free,
    output logic          err
);
    import refmgr_pkg::*;

    typedef struct packed {
        logic err;
    } rc_state_t;

    rc_state_t   s_d, s_q;
    logic [CW-1:0] cnt_d [DEPTH];
    logic [CW-1:0] cnt_q [DEPTH];
    logic [CW-1:0] cur;
    rel_kind_e     kind;

    always_comb begin
        cnt_d = cnt_q;
        s_d   = s_q;
        cur   = cnt_q[rl_addr];
        kind  = REL_NONE;

        if (rl_vld) begin
            if (cur == '0) begin
                kind = REL_BAD;
            end else if (cur == CW'(1)) begin
                kind = REL_LAST;
            end else begin
                kind = REL_DEC;
            end
        end
        if (kind == REL_DEC || kind == REL_LAST) begin
            cnt_d[rl_addr] = cur - 1'b1;
        end
        if (kind == REL_BAD) begin
            s_d.err = 1'b1;
        end
        if (cm_vld) begin
            cnt_d[cm_addr] = cm_fo;
        end
        cm_free = cm_vld && (cm_fo == '0);
        rl_free = kind == REL_LAST;
        err     = s_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                cnt_q[i] <= '0;
            end
        end else begin
            s_q   <= s_d;
            cnt_q <= cnt_d;
        end
    end

    p_bad_release_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rl_vld && cnt_q[rl_addr] == '0) |=> err);

    p_commit_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cm_vld |=> cnt_q[$past(cm_addr)] == $past(cm_fo));

    p_last_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rl_free && !(cm_vld && cm_addr == rl_addr)) |=> cnt_q[$past(rl_addr)] == '0);

endmodule

// File: rtl/bufaddr_refmgr.sv
module bufaddr_refmgr #(
    parameter int DEPTH = 512,
    parameter int NOUT  = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(NOUT + 1),
    parameter int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_req,
    output logic            alloc_vld,
    output logic [AW-1:0]   alloc_addr,
    input  logic            commit_vld,
    input  logic [AW-1:0]   commit_addr,
    input  logic [CW-1:0]   commit_fanout,
    input  logic            release_vld,
    input  logic [AW-1:0]   release_addr,
    output logic [CNTW-1:0] free_count,
    output logic            release_err
);

    logic cm_free, rl_free, pop_ok;

    refmgr_refcnt #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cm_vld  (commit_vld),
        .cm_addr (commit_addr),
        .cm_fo   (commit_fanout),
        .rl_vld  (release_vld),
        .rl_addr (release_addr),
        .cm_free (cm_free),
        .rl_free (rl_free),
        .err     (release_err)
    );

    refmgr_freeq #(.DEPTH(DEPTH), .AW(AW), .CNTW(CNTW)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop        (alloc_req),
        .push0      (cm_free),
        .push0_addr (commit_addr),
        .push1      (rl_free),
        .push1_addr (release_addr),
        .head_vld   (alloc_vld),
        .head_addr  (alloc_addr),
        .avail      (free_count),
        .pop_ok     (pop_ok)
    );

    p_free_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> free_count == $past(free_count) - CNTW'($past(pop_ok))
                 + CNTW'($past(cm_free)) + CNTW'($past(rl_free)));

    p_vld_means_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_vld == (free_count != '0));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        release_err |=> release_err);

endmodule

// File: tb/sim_bufaddr_refmgr.sv
module sim_bufaddr_refmgr;
    localparam int DEPTH = 16;
    localparam int NOUT  = 4;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(NOUT + 1);
    localparam int CNTW  = $clog2(DEPTH + 1);
    localparam int NVEC  = 11;

    typedef struct packed {
        logic            req;
        logic            cv;
        logic [AW-1:0]   ca;
        logic [CW-1:0]   cf;
        logic            rv;
        logic [AW-1:0]   ra;
        logic [CNTW-1:0] x_free;
        logic            x_err;
        logic [AW-1:0]   x_head;
    } vec_t;

    // req cv ca cf rv ra | free err head
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 1'b0, 4'd0, 3'd0, 1'b0, 4'd0, 5'd15, 1'b0, 4'd1}, // R2 pop 0
        '{1'b1, 1'b1, 4'd0, 3'd2, 1'b0, 4'd0, 5'd14, 1'b0, 4'd2}, // R2 pop 1, commit 0 x2
        '{1'b0, 1'b1, 4'd1, 3'd0, 1'b0, 4'd0, 5'd15, 1'b0, 4'd2}, // R6 fan-out 0
        '{1'b0, 1'b0, 4'd0, 3'd0, 1'b1, 4'd0, 5'd15, 1'b0, 4'd2}, // R4 first of two
        '{1'b0, 1'b0, 4'd0, 3'd0, 1'b1, 4'd0, 5'd16, 1'b0, 4'd2}, // R4 last of two
        '{1'b0, 1'b0, 4'd0, 3'd0, 1'b1, 4'd0, 5'd16, 1'b1, 4'd2}, // R7 unheld
        '{1'b1, 1'b0, 4'd0, 3'd0, 1'b0, 4'd0, 5'd15, 1'b1, 4'd3}, // R2
        '{1'b1, 1'b1, 4'd2, 3'd1, 1'b0, 4'd0, 5'd14, 1'b1, 4'd4}, // R2
        '{1'b1, 1'b0, 4'd0, 3'd0, 1'b1, 4'd2, 5'd14, 1'b1, 4'd5}, // R8
        '{1'b0, 1'b1, 4'd3, 3'd1, 1'b0, 4'd0, 5'd14, 1'b1, 4'd5}, // R10
        '{1'b0, 1'b1, 4'd4, 3'd0, 1'b1, 4'd3, 5'd16, 1'b1, 4'd5}  // R9 two returns
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            alloc_req = 1'b0;
    logic            alloc_vld;
    logic [AW-1:0]   alloc_addr;
    logic            commit_vld = 1'b0;
    logic [AW-1:0]   commit_addr = '0;
    logic [CW-1:0]   commit_fanout = '0;
    logic            release_vld = 1'b0;
    logic [AW-1:0]   release_addr = '0;
    logic [CNTW-1:0] free_count;
    logic            release_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bufaddr_refmgr #(.DEPTH(DEPTH), .NOUT(NOUT)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_req     (alloc_req),
        .alloc_vld     (alloc_vld),
        .alloc_addr    (alloc_addr),
        .commit_vld    (commit_vld),
        .commit_addr   (commit_addr),
        .commit_fanout (commit_fanout),
        .release_vld   (release_vld),
        .release_addr  (release_addr),
        .free_count    (free_count),
        .release_err   (release_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input vec_t v);
        @(negedge clk);
        alloc_req     = v.req;
        commit_vld    = v.cv;
        commit_addr   = v.ca;
        commit_fanout = v.cf;
        release_vld   = v.rv;
        release_addr  = v.ra;
        @(posedge clk);
        #2;
        alloc_req   = 1'b0;
        commit_vld  = 1'b0;
        release_vld = 1'b0;
    endtask

    task automatic check_reset_state(input string tag);
        chk({tag, " R1 free_count"}, int'(free_count), DEPTH);
        chk({tag, " R1 alloc_vld"}, int'(alloc_vld), 1);
        chk({tag, " R1 alloc_addr"}, int'(alloc_addr), 0);
        chk({tag, " R1 release_err"}, int'(release_err), 0);
    endtask

    initial begin
        int recyc [5];
        recyc = '{1, 0, 2, 4, 3};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_reset_state("start");

        for (int i = 0; i < NVEC; i++) begin
            step(TBL[i]);
            chk($sformatf("vec%0d R10 free_count", i), int'(free_count), int'(TBL[i].x_free));
            chk($sformatf("vec%0d R7 release_err", i), int'(release_err), int'(TBL[i].x_err));
            chk($sformatf("vec%0d R2 alloc_addr", i), int'(alloc_addr), int'(TBL[i].x_head));
        end

        // R5: drain the remaining fresh addresses in ascending order
        for (int k = 5; k < DEPTH; k++) begin
            @(negedge clk);
            chk($sformatf("R5 fresh order k=%0d", k), int'(alloc_addr), k);
            alloc_req = 1'b1;
            @(posedge clk);
            #2;
            alloc_req = 1'b0;
        end
        // R5 / R9: recycled addresses come back in entry order
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk($sformatf("R5 R9 recycled order k=%0d", k), int'(alloc_addr), recyc[k]);
            chk("R3 vld while nonempty", int'(alloc_vld), 1);
            alloc_req = 1'b1;
            @(posedge clk);
            #2;
            alloc_req = 1'b0;
        end
        @(negedge clk);
        chk("R3 empty free_count", int'(free_count), 0);
        chk("R3 empty alloc_vld", int'(alloc_vld), 0);
        alloc_req = 1'b1;
        @(posedge clk);
        #2;
        alloc_req = 1'b0;
        chk("R3 req on empty free_count", int'(free_count), 0);
        chk("R3 req on empty alloc_vld", int'(alloc_vld), 0);

        // R4: fan-out 3 held through two releases, freed on the third
        step('{1'b0, 1'b1, 4'd7, 3'd3, 1'b0, 4'd0, 5'd0, 1'b1, 4'd0});
        step('{1'b0, 1'b0, 4'd0, 3'd0, 1'b1, 4'd7, 5'd0, 1'b1, 4'd0});
        chk("R4 after release 1 of 3", int'(free_count), 0);
        step('{1'b0, 1'b0, 4'd0, 3'd0, 1'b1, 4'd7, 5'd0, 1'b1, 4'd0});
        chk("R4 after release 2 of 3", int'(free_count), 0);
        step('{1'b0, 1'b0, 4'd0, 3'd0, 1'b1, 4'd7, 5'd0, 1'b1, 4'd0});
        chk("R4 after release 3 of 3", int'(free_count), 1);
        chk("R4 freed address offered", int'(alloc_addr), 7);
        chk("R7 flag stays set", int'(release_err), 1);

        // R1 again after a second reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_reset_state("rerun");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule